// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table kept in memory. Pages are 1 KB, so the low 10 bits of the address are the offset within the page. The remaining 22-bit page number is split into a 12-bit index into the top-level table and a 10-bit index into a second-level table. The block first reads the top-level entry. That entry points at the 1 KB-aligned page holding the second-level table. The block then reads the second-level entry, which names the physical frame.

A request is presented with a valid/ready handshake and is taken only while the walker is idle. The two table reads go out one at a time on a single read port. Each read holds its request until the memory answers with a valid pulse.

When the walk ends, the walker gives a one-cycle response. The response carries either the physical address or a code naming the table level whose entry was marked invalid. The base address of the top-level table sits in a register that can be written at any time. Each walk uses the value it found when the request was accepted.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready is 1 and mem_rd_en and rsp_valid are both 0. While req_ready is 1, no read is requested and no response is given.
- R2: The first read of a walk goes to base + 4 * vaddr[31:20], where base is the table base register value at acceptance.
- R3: When the first entry has bit 0 set, the second read goes to {entry1[31:10], 10'b0} + 4 * vaddr[19:10].
- R4: When both entries have bit 0 set, the response carries rsp_fault = 2'd0 and rsp_paddr = {entry2[31:10], vaddr[9:0]}.
- R5: When the first entry has bit 0 clear, the walk ends after that single read with rsp_fault = 2'd1 and rsp_paddr = 0.
- R6: When the second entry has bit 0 clear, the response carries rsp_fault = 2'd2 and rsp_paddr = 0, after exactly two reads.
- R7: A read request keeps mem_rd_en high and mem_rd_addr unchanged until mem_rd_valid is seen. The two reads never overlap.
- R8: req_ready drops in the cycle after a request is accepted and stays low until the response cycle has passed. A request offered during a walk is ignored: it changes neither that walk's result nor starts a new walk.
- R9: rsp_valid is a single-cycle pulse, given once per accepted request. rsp_paddr and rsp_fault are 0 whenever rsp_valid is 0.
- R10: A write to the table base register takes effect for walks accepted after the write. A walk already in progress keeps the base it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New top-level table base address |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| mem_rd_en | output | 1 | Table read requested |
| mem_rd_addr | output | 32 | Byte address of the table entry to read |
| mem_rd_valid | input | 1 | Read data valid pulse from memory |
| mem_rd_data | input | 32 | Table entry; bit 0 valid, bits 31:10 frame |
| rsp_valid | output | 1 | One-cycle walk result strobe |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 top-level invalid, 2 second-level invalid |

## Verification
The assertions assume that memory raises mem_rd_valid only in answer to a pending read. They also assume it drops mem_rd_valid after one cycle and never answers while mem_rd_en is low. The bench's memory model keeps to this. It answers each read once, after a chosen latency of zero or more cycles, and then holds mem_rd_valid low for at least one cycle. Requests are driven only on the falling clock edge. Any request offered during a walk is a short pulse that ends before the response comes.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OUTER = 2'd1,
    WS_INNER = 2'd2,
    WS_DONE  = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_OUTER = 2'd1,
    FLT_INNER = 2'd2
  } walk_fault_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base
);

  always_ff @(posedge clk) begin
    if (!rst_n)  base <= RST_BASE;
    else if (we) base <= wdata;
  end

endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rd_valid,
  input  logic        entry_ok,
  output walk_state_e state
);

  walk_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      WS_IDLE:  if (start)    nxt = WS_OUTER;
      WS_OUTER: if (rd_valid) nxt = entry_ok ? WS_INNER : WS_DONE;
      WS_INNER: if (rd_valid) nxt = WS_DONE;
      WS_DONE:                nxt = WS_IDLE;
      default:                nxt = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= WS_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/ptw_path.sv
module ptw_path
  import ptw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 10,
  parameter int INNER_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_state_e       state,
  input  logic              start,
  input  logic [ADDR_W-1:0] vaddr_in,
  input  logic [ADDR_W-1:0] base,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] paddr,
  output walk_fault_e       fault,
  output logic              entry_ok
);

  localparam int OUTER_W = ADDR_W - OFF_W - INNER_W;
  localparam int SLOT_SH = $clog2(ADDR_W / 8);
  localparam int IN_LO   = OFF_W;
  localparam int OUT_LO  = OFF_W + INNER_W;

  // Entry address within the top-level table.
  function automatic logic [ADDR_W-1:0] outer_slot(
    input logic [ADDR_W-1:0]  tbl,
    input logic [OUTER_W-1:0] idx
  );
    return tbl + (ADDR_W'(idx) << SLOT_SH);
  endfunction

  // Entry address within the second-level table named by an entry.
  function automatic logic [ADDR_W-1:0] inner_slot(
    input logic [ADDR_W-1:0]  ent,
    input logic [INNER_W-1:0] idx
  );
    return {ent[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + (ADDR_W'(idx) << SLOT_SH);
  endfunction

  // Physical address from a frame entry and the page offset.
  function automatic logic [ADDR_W-1:0] frame_join(
    input logic [ADDR_W-1:0] ent,
    input logic [OFF_W-1:0]  off
  );
    return {ent[ADDR_W-1:OFF_W], off};
  endfunction

  logic [ADDR_W-1:0] va_q;
  logic              outer_resp, inner_resp;

  assign entry_ok   = rd_data[0];
  assign outer_resp = (state == WS_OUTER) && rd_valid;
  assign inner_resp = (state == WS_INNER) && rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q    <= '0;
      rd_addr <= '0;
      paddr   <= '0;
      fault   <= FLT_NONE;
    end else if (start) begin
      va_q    <= vaddr_in;
      rd_addr <= outer_slot(base, vaddr_in[ADDR_W-1:OUT_LO]);
      paddr   <= '0;
      fault   <= FLT_NONE;
    end else if (outer_resp) begin
      if (entry_ok) rd_addr <= inner_slot(rd_data, va_q[OUT_LO-1:IN_LO]);
      else          fault   <= FLT_OUTER;
    end else if (inner_resp) begin
      if (entry_ok) paddr <= frame_join(rd_data, va_q[OFF_W-1:0]);
      else          fault <= FLT_INNER;
    end
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                OFF_W    = 10,
  parameter int                INNER_W  = 10,
  parameter logic [ADDR_W-1:0] RST_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault
);

  walk_state_e       state;
  walk_fault_e       fault;
  logic [ADDR_W-1:0] tbl_base, paddr_q;
  logic              walk_start, entry_ok;

  assign walk_start = req_valid && req_ready;

  ptw_base_reg #(.ADDR_W(ADDR_W), .RST_BASE(RST_BASE)) u_base (
    .clk(clk), .rst_n(rst_n), .we(base_we), .wdata(base_wdata), .base(tbl_base)
  );

  ptw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .rd_valid(mem_rd_valid),
    .entry_ok(entry_ok), .state(state)
  );

  ptw_path #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INNER_W(INNER_W)) u_path (
    .clk(clk), .rst_n(rst_n), .state(state), .start(walk_start),
    .vaddr_in(req_vaddr), .base(tbl_base), .rd_valid(mem_rd_valid),
    .rd_data(mem_rd_data), .rd_addr(mem_rd_addr), .paddr(paddr_q),
    .fault(fault), .entry_ok(entry_ok)
  );

  assign req_ready = (state == WS_IDLE);
  assign mem_rd_en = (state == WS_OUTER) || (state == WS_INNER);
  assign rsp_valid = (state == WS_DONE);
  assign rsp_paddr = rsp_valid ? paddr_q : '0;
  assign rsp_fault = rsp_valid ? fault   : FLT_NONE;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_fault
);

  // R1: an idle walker neither reads nor responds
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_en && !rsp_valid));

  // R2: an accepted request is followed at once by a table read
  a_r2_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_en);

  // R7: a pending read holds its request and address
  a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr)));

  // R8: ready drops after acceptance
  a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: the response is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: response fields are zero outside the response cycle
  a_r9_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_paddr == '0 && rsp_fault == 2'd0));

  // R5/R6: a faulted walk carries no physical address
  a_r5_fault_no_paddr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);

  // R6: fault code is one of the three defined values
  a_r6_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'd3);

endmodule

bind ptw_walker ptw_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
  .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE_A     = 32'h0004_0000;
  localparam logic [31:0] BASE_B     = 32'h0006_1000;

  // vector: {vaddr[31:0], outer_ok, inner_ok, frame[21:0], latency[3:0]}
  localparam int NVEC = 8;
  localparam logic [59:0] VEC [NVEC] = '{
    {32'h0000_0000, 1'b1, 1'b1, 22'h00_0123, 4'd0},
    {32'hFFFF_FFFF, 1'b1, 1'b1, 22'h3F_FFFF, 4'd1},
    {32'h1234_5678, 1'b1, 1'b1, 22'h2A_5A5A, 4'd3},
    {32'h800F_FC00, 1'b1, 1'b1, 22'h00_0001, 4'd2},
    {32'h0010_03FF, 1'b0, 1'b1, 22'h11_1111, 4'd0},
    {32'hABC0_0400, 1'b0, 1'b0, 22'h22_2222, 4'd4},
    {32'h7FF3_FF01, 1'b1, 1'b0, 22'h33_3333, 4'd1},
    {32'h0000_0C00, 1'b1, 1'b0, 22'h00_0000, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid;
  logic [31:0] mem_rd_data;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  // memory model
  logic [31:0] mem [logic [31:0]];
  int          lat = 0;
  int          wait_cnt;
  logic        log_clr = 1'b0;
  int          rd_n;
  logic [31:0] rd_log [4];
  logic [31:0] held_addr;
  logic        moved;

  always @(posedge clk) begin
    if (!rst_n || log_clr) begin
      rd_n  <= 0;
      moved <= 1'b0;
    end
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
      wait_cnt     <= 0;
    end else if (mem_rd_valid) begin
      mem_rd_valid <= 1'b0;
    end else if (mem_rd_en) begin
      if (wait_cnt == 0) held_addr <= mem_rd_addr;
      else if (mem_rd_addr != held_addr) moved <= 1'b1;
      if (wait_cnt >= lat) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
        rd_log[rd_n & 3] <= mem_rd_addr;
        if (!log_clr) rd_n <= rd_n + 1;
        wait_cnt <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Fill the two tables for one address; returns the expected read addresses.
  task automatic fill(input logic [31:0] base, input logic [31:0] va, input logic ook,
                      input logic iok, input logic [21:0] frame,
                      output logic [31:0] a0, output logic [31:0] a1);
    logic [21:0] ptr;
    mem.delete();
    ptr = 22'h2A0 + 22'(va[31:20]);
    a0  = base + {18'b0, va[31:20], 2'b00};
    a1  = {ptr, 10'b0} + {20'b0, va[19:10], 2'b00};
    mem[a0] = {ptr, 9'b0, ook};
    mem[a1] = {frame, 9'b0, iok};
  endtask

  // Issue a request and wait for the response; leaves the bench at a falling edge.
  task automatic walk(input logic [31:0] va, output int busy_bad, output int cyc);
    @(negedge clk);
    log_clr   = 1'b1;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    log_clr   = 1'b0;
    req_valid = 1'b0;
    busy_bad  = 0;
    cyc       = 0;
    while (!rsp_valid && cyc < 200) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    int busy_bad, cyc;
    logic [31:0] a0, a1, exp_pa;
    logic [1:0]  exp_f;
    int          exp_n;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    check("R1 no read after reset", 32'(mem_rd_en), 32'd0);
    check("R1 no response after reset", 32'(rsp_valid), 32'd0);

    base_we = 1'b1; base_wdata = BASE_A;
    @(negedge clk);
    base_we = 1'b0;

    // table-driven walks: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] va;
      va  = VEC[v][59:28];
      lat = int'(VEC[v][3:0]);
      fill(BASE_A, va, VEC[v][27], VEC[v][26], VEC[v][25:4], a0, a1);
      if (!VEC[v][27])     begin exp_f = 2'd1; exp_pa = '0; exp_n = 1; end
      else if (!VEC[v][26]) begin exp_f = 2'd2; exp_pa = '0; exp_n = 2; end
      else begin exp_f = 2'd0; exp_pa = {VEC[v][25:4], va[9:0]}; exp_n = 2; end
      walk(va, busy_bad, cyc);
      check("R9 response seen", 32'(rsp_valid), 32'd1);
      check("R8 ready low during walk", 32'(busy_bad), 32'd0);
      check("R4/R5/R6 fault code", 32'(rsp_fault), 32'(exp_f));
      check("R4/R5/R6 physical address", rsp_paddr, exp_pa);
      check("R5/R6 read count", 32'(rd_n), 32'(exp_n));
      check("R2 outer read address", rd_log[0], a0);
      if (exp_n == 2) check("R3 inner read address", rd_log[1], a1);
      check("R7 address held while waiting", 32'(moved), 32'd0);
      @(negedge clk);
      check("R9 pulse ends", 32'(rsp_valid), 32'd0);
      check("R9 fields quiet", rsp_paddr | 32'(rsp_fault), 32'd0);
      check("R1 ready again", 32'(req_ready), 32'd1);
    end

    // R10: base write during a walk does not affect it
    lat = 4;
    fill(BASE_A, 32'h0050_1234, 1'b1, 1'b1, 22'h0A_BCDE, a0, a1);
    @(negedge clk);
    log_clr = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0050_1234;
    @(negedge clk);
    log_clr = 1'b0; req_valid = 1'b0;
    base_we = 1'b1; base_wdata = BASE_B;
    @(negedge clk);
    base_we = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
    check("R10 in-flight walk keeps old base", rd_log[0], a0);
    check("R10 in-flight result", rsp_paddr, {22'h0A_BCDE, 10'h234});
    fill(BASE_B, 32'h0050_1234, 1'b1, 1'b1, 22'h0A_BCDE, a0, a1);
    walk(32'h0050_1234, busy_bad, cyc);
    check("R10 new base used", rd_log[0], a0);
    check("R10 result with new base", rsp_paddr, {22'h0A_BCDE, 10'h234});
    @(negedge clk);

    // R8: a request offered mid-walk is ignored
    lat = 3;
    fill(BASE_B, 32'h0123_4567, 1'b1, 1'b1, 22'h15_5555, a0, a1);
    @(negedge clk);
    log_clr = 1'b1; req_valid = 1'b1; req_vaddr = 32'h0123_4567;
    @(negedge clk);
    log_clr = 1'b0; req_vaddr = 32'hFED0_0000;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
    check("R8 mid-walk request ignored (result)", rsp_paddr, {22'h15_5555, 10'h167});
    check("R8 mid-walk request ignored (reads)", 32'(rd_n), 32'd2);
    repeat (3) @(negedge clk);
    check("R8 no second walk started", 32'(mem_rd_en), 32'd0);
    check("R8 idle after ignored request", 32'(req_ready), 32'd1);
    check("R8 no extra read", 32'(rd_n), 32'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule